// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises bytes (optionally with a ninth bit) onto an asynchronous line. Each frame is a low start bit, the data bits least significant first, an optional ninth bit, and a high stop bit. A one-entry holding register sits in front of the frame shifter. Software can therefore write the next word while the current one is still on the line, and consecutive frames leave with no idle time between them.

Bit timing comes from an external one-cycle `bit_tick` pulse. The block only reacts to those pulses and never divides the clock itself. `hold_empty` is meant to serve as an interrupt request. `shift_empty` is a polled status. Dropping `tx_en` aborts everything in flight and releases the line driver.

Top module: `uart_dbtx`

## Requirements
- R1: With `nine_bit_en` low at write time, a frame is one 0 start bit, then `wr_data[0]` through `wr_data[7]` in that order, then one 1 stop bit (10 bit periods). The line is 1 whenever no frame is being sent.
- R2: With `nine_bit_en` high at write time, `bit9_in` is sent as an extra bit between `wr_data[7]` and the stop bit (11 bit periods). The mode and the ninth-bit value are captured on the write cycle. Later changes to `nine_bit_en` or `bit9_in` have no effect on that frame.
- R3: `hold_empty` rises only when the holding register hands its word to the shifter. With the shifter idle, a write at clock edge N clears `hold_empty` after edge N, and the handoff at edge N+1 sets it again and clears `shift_empty`.
- R4: `hold_empty` clears only through an accepted write. A write while the holding register is full is ignored, and no frame is ever sent for it.
- R5: `shift_empty` is 0 from the handoff until the tick that ends the stop bit of the last frame, and is 1 otherwise while nothing is pending.
- R6: If the holding register is full when a stop bit ends, the next start bit is driven on that same tick, with no idle period.
- R7: `ser_out` changes only on clock edges where `bit_tick` is high, so each frame bit lasts exactly one tick period.
- R8: Deasserting `tx_en` causes the next edge to drive `ser_oe` low, force `ser_out` high, clear the shifter (`shift_empty` = 1), and discard any held word. After re-enabling, none of the discarded data is sent.
- R9: While `tx_en` is low, writes are ignored and `hold_empty` reads 0. With `tx_en` high and nothing pending, `hold_empty` reads 1.
- R10: After reset, `ser_out` = 1, `ser_oe` = 0, `shift_empty` = 1, and `hold_empty` = 0 while `tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; low aborts and releases the line |
| nine_bit_en | input | 1 | Selects nine-bit frames, sampled on a write |
| bit9_in | input | 1 | Ninth data bit, sampled on a write |
| wr_stb | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | DATA_W | Data word to send |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| ser_out | output | 1 | Serial line |
| ser_oe | output | 1 | Line driver enable (low = high impedance) |
| hold_empty | output | 1 | Holding register free; interrupt request |
| shift_empty | output | 1 | Shifter idle, polled status |

## Verification
The bench builds the block with `DATA_W` = 8 and pulses `bit_tick` every fourth clock, so a full nine-bit frame lasts only 44 clocks. Frames can therefore be logged tick by tick and compared bit for bit. This short bit period makes several sequences cheap to reach: back-to-back frame pairs, a write rejected while the holding register and shifter are both occupied, and an abort partway through a frame followed by re-enable. A per-edge monitor confirms that the line never moves between ticks.

// File: rtl/uart_dbtx_pkg.sv
package uart_dbtx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // nothing loaded
        PH_WAIT = 2'd1,   // loaded, waiting for the first tick to drive start
        PH_SEND = 2'd2    // frame bits on the line
    } tx_phase_e;

    function automatic int frame_bits(input int data_w);
        return data_w + 3;   // start + data + ninth + stop
    endfunction

endpackage

// File: rtl/uart_dbtx_hold.sv
module uart_dbtx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_nine,
    input  logic              wr_bit9,
    input  logic              take,
    output logic              full,
    output logic              nine,
    output logic              bit9,
    output logic [DATA_W-1:0] data,
    output logic              empty_flag
);

    typedef struct packed {
        logic              full;
        logic              nine;
        logic              bit9;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (!en) begin
            h_d.full = 1'b0;
        end else if (take) begin
            h_d.full = 1'b0;
        end else if (wr_stb && !h_q.full) begin
            h_d.full = 1'b1;
            h_d.nine = wr_nine;
            h_d.bit9 = wr_bit9;
            h_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign full       = h_q.full;
    assign nine       = h_q.nine;
    assign bit9       = h_q.bit9;
    assign data       = h_q.data;
    assign empty_flag = en & ~h_q.full;

    // R3
    hold_rise_by_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(empty_flag) && $past(en)) |-> $past(take));

    // R4
    hold_write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_stb && !full) |=> !empty_flag || !en);

    // R4
    hold_full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_stb && full && !take) |=> ($stable(data) && (full || !en)));

endmodule

// File: rtl/uart_dbtx_shifter.sv
module uart_dbtx_shifter
    import uart_dbtx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              hold_full,
    input  logic              hold_nine,
    input  logic              hold_bit9,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              line,
    output logic              idle
);

    localparam int FRAME_W = frame_bits(DATA_W);
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LEN_NINE  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LEN_PLAIN = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        tx_phase_e          phase;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   idx;
        logic [CNT_W-1:0]   last;
        logic               line;
    } shf_t;

    localparam shf_t SHF_RST = '{phase: PH_IDLE, sh: '1, idx: '0, last: '0, line: 1'b1};

    shf_t s_d, s_q;
    logic [FRAME_W-1:0] frm_new;
    logic [CNT_W-1:0]   len_new;

    always_comb begin
        frm_new = {1'b1, (hold_nine ? hold_bit9 : 1'b1), hold_data, 1'b0};
        len_new = hold_nine ? LEN_NINE : LEN_PLAIN;
        s_d     = s_q;
        take    = 1'b0;
        if (!en) begin
            s_d = SHF_RST;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    if (hold_full) begin
                        take      = 1'b1;
                        s_d.phase = PH_WAIT;
                        s_d.sh    = frm_new;
                        s_d.idx   = '0;
                        s_d.last  = len_new;
                    end
                end
                PH_WAIT: begin
                    if (tick) begin
                        s_d.line  = s_q.sh[0];
                        s_d.sh    = {1'b1, s_q.sh[FRAME_W-1:1]};
                        s_d.idx   = CNT_W'(1);
                        s_d.phase = PH_SEND;
                    end
                end
                PH_SEND: begin
                    if (tick) begin
                        if (s_q.idx == s_q.last) begin
                            if (hold_full) begin
                                take     = 1'b1;
                                s_d.line = frm_new[0];
                                s_d.sh   = {1'b1, frm_new[FRAME_W-1:1]};
                                s_d.idx  = CNT_W'(1);
                                s_d.last = len_new;
                            end else begin
                                s_d.phase = PH_IDLE;
                                s_d.line  = 1'b1;
                            end
                        end else begin
                            s_d.line = s_q.sh[0];
                            s_d.sh   = {1'b1, s_q.sh[FRAME_W-1:1]};
                            s_d.idx  = s_q.idx + CNT_W'(1);
                        end
                    end
                end
                default: s_d = SHF_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SHF_RST;
        else        s_q <= s_d;
    end

    assign line = s_q.line;
    assign idle = (s_q.phase == PH_IDLE);

    // R7
    line_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(line));

    // R6
    back_to_back_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && s_q.phase == PH_SEND && s_q.idx == s_q.last && hold_full) |=> !line);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> line);

    // R5
    busy_starts_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> $past(take));

endmodule

// File: rtl/uart_dbtx.sv
module uart_dbtx
    import uart_dbtx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              nine_bit_en,
    input  logic              bit9_in,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit_tick,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              hold_empty,
    output logic              shift_empty
);

    typedef struct packed {
        logic oe;
    } top_t;

    top_t t_d, t_q;

    logic              h_full, h_nine, h_bit9, take;
    logic [DATA_W-1:0] h_data;

    uart_dbtx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (tx_en),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .wr_nine    (nine_bit_en),
        .wr_bit9    (bit9_in),
        .take       (take),
        .full       (h_full),
        .nine       (h_nine),
        .bit9       (h_bit9),
        .data       (h_data),
        .empty_flag (hold_empty)
    );

    uart_dbtx_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .tick      (bit_tick),
        .hold_full (h_full),
        .hold_nine (h_nine),
        .hold_bit9 (h_bit9),
        .hold_data (h_data),
        .take      (take),
        .line      (ser_out),
        .idle      (shift_empty)
    );

    always_comb begin
        t_d    = t_q;
        t_d.oe = tx_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign ser_oe = t_q.oe;

    // R8
    disable_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!ser_oe && ser_out && shift_empty));

    // R9
    disabled_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !hold_empty);

endmodule

// File: tb/uart_dbtx_tb.sv
module uart_dbtx_tb;

    localparam int DATA_W  = 8;
    localparam int BIT_CYC = 4;
    localparam int NVEC    = 6;
    // {nine_bit_en, bit9_in, data}
    localparam logic [9:0] VEC [NVEC] = '{
        10'b0_0_01010101, 10'b0_0_10100011, 10'b1_1_00000000,
        10'b1_0_11111111, 10'b0_0_10000001, 10'b1_1_00111100
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, nine_bit_en = 1'b0, bit9_in = 1'b0, wr_stb = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic bit_tick = 1'b0;
    logic ser_out, ser_oe, hold_empty, shift_empty;

    int total = 0, fails = 0, viol = 0, tcnt = 0, log_n = 0;
    logic ln [256];

    always #2.5 clk = ~clk;

    uart_dbtx #(.DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .nine_bit_en(nine_bit_en),
        .bit9_in(bit9_in), .wr_stb(wr_stb), .wr_data(wr_data), .bit_tick(bit_tick),
        .ser_out(ser_out), .ser_oe(ser_oe), .hold_empty(hold_empty),
        .shift_empty(shift_empty)
    );

    always @(negedge clk) begin
        if (tcnt == BIT_CYC - 1) begin bit_tick <= 1'b1; tcnt <= 0; end
        else begin bit_tick <= 1'b0; tcnt <= tcnt + 1; end
    end

    // tick log and R7 monitor
    logic out_prev = 1'b1;
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (bit_tick) begin
                if (log_n < 256) ln[log_n] = ser_out;
                log_n = log_n + 1;
            end else if (tx_en && ser_out !== out_prev) begin
                viol = viol + 1;
            end
        end
        out_prev = ser_out;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", total, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1; fails = fails + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic nine, input logic b9, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; nine_bit_en = nine; bit9_in = b9; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_done();
        repeat (3) @(negedge clk);
        while (!(shift_empty && hold_empty)) @(negedge clk);
        repeat (BIT_CYC) @(negedge clk);
    endtask

    function automatic int first_zero(input int from);
        for (int i = from; i < log_n && i < 256; i++)
            if (ln[i] == 1'b0) return i;
        return -1;
    endfunction

    // compares one logged frame starting at tick index s; returns its length
    task automatic chk_frame(input int s, input logic nine, input logic b9,
                             input logic [7:0] d, input string req, output int len);
        logic [11:0] act, exp;
        len = nine ? 11 : 10;
        exp = '1; act = '1;
        exp[0] = 1'b0;
        for (int i = 0; i < 8; i++) exp[i+1] = d[i];
        if (nine) exp[9] = b9;
        exp[len-1] = 1'b1;
        for (int i = 0; i < len; i++)
            act[i] = (s >= 0 && s + i < log_n) ? ln[s+i] : 1'bx;
        chk(act === exp, req, {20'd0, act}, {20'd0, exp});
    endtask

    initial begin
        int s, len, s2;
        logic all_one;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(ser_out === 1'b1, "R10 ser_out", ser_out, 1);
        chk(ser_oe === 1'b0, "R10 ser_oe", ser_oe, 0);
        chk(shift_empty === 1'b1, "R10 shift_empty", shift_empty, 1);
        chk(hold_empty === 1'b0, "R10 hold_empty", hold_empty, 0);

        // R9 write while disabled is ignored
        write_word(1'b0, 1'b0, 8'h00);
        tx_en = 1'b1;
        @(negedge clk);
        chk(hold_empty === 1'b1, "R9 hold_empty on enable", hold_empty, 1);
        chk(ser_oe === 1'b1, "R8 ser_oe on enable", ser_oe, 1);
        log_n = 0;
        repeat (14 * BIT_CYC) @(negedge clk);
        chk(first_zero(0) == -1 && shift_empty, "R9 no frame from disabled write", first_zero(0), 32'hffffffff);

        // table of frames: R1 / R2
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk); log_n = 0;
            write_word(VEC[v][9], VEC[v][8], VEC[v][7:0]);
            wait_done();
            s = first_zero(0);
            chk_frame(s, VEC[v][9], VEC[v][8], VEC[v][7:0],
                      VEC[v][9] ? "R2 nine-bit frame" : "R1 eight-bit frame", len);
        end

        // R2 mode and ninth bit latched at the write
        @(negedge clk); log_n = 0;
        @(negedge clk);
        wr_stb = 1'b1; nine_bit_en = 1'b1; bit9_in = 1'b1; wr_data = 8'h5A;
        @(negedge clk);
        wr_stb = 1'b0; nine_bit_en = 1'b0; bit9_in = 1'b0;
        wait_done();
        chk_frame(first_zero(0), 1'b1, 1'b1, 8'h5A, "R2 latched at write", len);

        // R3 / R5 handoff timing with idle shifter
        @(negedge clk);
        wr_stb = 1'b1; nine_bit_en = 1'b0; wr_data = 8'hC3;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(hold_empty === 1'b0, "R3 cleared by write", hold_empty, 0);
        chk(shift_empty === 1'b1, "R5 idle before handoff", shift_empty, 1);
        @(negedge clk);
        chk(hold_empty === 1'b1, "R3 set on handoff", hold_empty, 1);
        chk(shift_empty === 1'b0, "R5 busy after handoff", shift_empty, 0);
        wait_done();
        chk(shift_empty === 1'b1, "R5 idle after stop", shift_empty, 1);

        // R6 back to back, R4 write while full ignored
        @(negedge clk); log_n = 0;
        write_word(1'b1, 1'b0, 8'h96);
        while (!hold_empty) @(negedge clk);
        write_word(1'b0, 1'b0, 8'h3E);
        chk(hold_empty === 1'b0, "R4 holding full", hold_empty, 0);
        write_word(1'b0, 1'b0, 8'hFF);
        wait_done();
        s = first_zero(0);
        chk_frame(s, 1'b1, 1'b0, 8'h96, "R6 first frame", len);
        s2 = s + len;
        chk(s2 < log_n && ln[s2] === 1'b0, "R6 no gap before second start", s2 < log_n ? ln[s2] : 1'bx, 0);
        chk_frame(s2, 1'b0, 1'b0, 8'h3E, "R6 second frame", len);
        chk(first_zero(s2 + len) == -1, "R4 rejected write not sent", first_zero(s2 + len), 32'hffffffff);

        // R8 abort mid-frame, with a word also held
        @(negedge clk); log_n = 0;
        write_word(1'b0, 1'b0, 8'h00);
        while (!hold_empty) @(negedge clk);
        write_word(1'b0, 1'b0, 8'h00);
        while (first_zero(0) == -1) @(negedge clk);
        repeat (2 * BIT_CYC) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(ser_oe === 1'b0, "R8 oe low", ser_oe, 0);
        chk(ser_out === 1'b1, "R8 line high", ser_out, 1);
        chk(shift_empty === 1'b1, "R8 shifter reset", shift_empty, 1);
        chk(hold_empty === 1'b0, "R9 disabled hold_empty", hold_empty, 0);
        tx_en = 1'b1;
        @(negedge clk);
        chk(hold_empty === 1'b1 && shift_empty === 1'b1, "R8 held word discarded",
            {hold_empty, shift_empty}, 2'b11);
        log_n = 0;
        repeat (25 * BIT_CYC) @(negedge clk);
        all_one = (first_zero(0) == -1);
        chk(all_one, "R8 nothing sent after re-enable", first_zero(0), 32'hffffffff);

        chk(viol == 0, "R7 line moved between ticks", viol, 0);
        summary();
    end

endmodule